// File: doc/BRIEF.md
# Maskable Interrupt Acknowledge and In-Service Level Tracker

This block sits beside the interrupt controller of a processor core. It decides in which cycle a pending maskable interrupt request may be acknowledged. It keeps an eight-bit record of the priority levels whose handlers have been entered and not yet returned from. It also holds the global interrupt-disable flag. Every request line carries a 3-bit level, and level 0 is the most urgent. A request is taken only when the flag is clear and its level outranks every level already in service, which lets handlers nest strictly by priority.

The core drives strobes for the disable, enable and return-from-interrupt instructions. The return strobe comes with a qualifier that marks a return from non-maskable or exception servicing. The core also has a write port that restores the flag when the status word is reloaded. A non-maskable event input is acknowledged at once, whatever the flag holds.

The acknowledge is a one-cycle control pulse with no back-pressure. The chosen request index and level travel with it. Requesters are expected to drop their line after the pulse. A requester that cannot be taken keeps its line high and simply waits.

Top module: `irq_inservice_ctl`

## Requirements
- R1: After reset `isr_bits` is 0x00, `int_disable` is 1 and `ack_valid` is 0.
- R2: A maskable request is not acknowledged while `int_disable` is 1. A request that is still asserted after the flag returns to 0 is acknowledged on the next clock edge.
- R3: A maskable acknowledge pulses `ack_valid` for exactly one cycle with `ack_nmi` at 0. On that same edge, bit `ack_level` of `isr_bits` is set and `int_disable` becomes 1.
- R4: Among eligible requests, the one with the numerically smallest level wins. Requests with equal levels go to the lowest request index.
- R5: A request is eligible only if its level number is strictly smaller than the lowest-numbered set bit of `isr_bits`. When no bit is set, every level is eligible.
- R6: A return strobe with `reti_nmi` at 0 clears only the lowest-numbered set bit of `isr_bits`. On an empty register it has no effect.
- R7: A return strobe with `reti_nmi` at 1 leaves `isr_bits` unchanged.
- R8: `di_stb` sets the flag and `ei_stb` clears it, and `flag_wr_en` loads `flag_wr_data`. When several act in the same cycle, a maskable acknowledge wins over the write, the write wins over `di_stb`, and `di_stb` wins over `ei_stb`.
- R9: `nmi_req` produces `ack_valid` with `ack_nmi` at 1 on the next edge, even when the flag is 1. `isr_bits` and the flag stay unchanged, and a maskable acknowledge is held off for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Maskable request lines |
| req_level | input | NUM_REQ*3 | Level of each request, request i in bits [3i+2:3i] |
| nmi_req | input | 1 | Non-maskable interrupt or exception strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| reti_nmi | input | 1 | Return is from non-maskable or exception servicing |
| flag_wr_en | input | 1 | Load the disable flag from the status word |
| flag_wr_data | input | 1 | Value to load |
| ack_valid | output | 1 | Acknowledge pulse |
| ack_nmi | output | 1 | Acknowledge is for the non-maskable event |
| ack_index | output | IDX_W | Index of the acknowledged request |
| ack_level | output | 3 | Level of the acknowledged request |
| isr_bits | output | 8 | In-service level register, read only |
| int_disable | output | 1 | Global maskable-interrupt disable flag |

## Verification
A stale or corrupted in-service bit has two visible effects. It raises or lowers the nesting ceiling, so the first request at a level near that ceiling is refused or taken wrongly on the very next edge. A return that clears the wrong bit shows up the same way on the following acknowledge decision. A flag left at the wrong value shows up directly on `int_disable` one edge after the strobe, and on `ack_valid` one edge after that. The directed scenarios therefore probe the levels just above and just below the current ceiling, and each return is followed by a request that can only be taken if the right bit was cleared.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef logic [LVL_W-1:0]   level_t;
  typedef logic [NUM_LVL-1:0] lvl_mask_t;

  typedef struct packed {
    logic   hit;
    level_t lvl;
  } first_t;

  // lowest-numbered set bit = most urgent level in service
  function automatic first_t first_set(lvl_mask_t m);
    first_t r;
    r = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (m[i]) begin
        r.hit = 1'b1;
        r.lvl = level_t'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_isr_track.sv
module irq_isr_track
  import irq_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_en,
  input  level_t    set_lvl,
  input  logic      clr_en,
  output lvl_mask_t isr_q,
  output logic      ceil_hit,
  output level_t    ceil_lvl
);
  first_t    top_q;
  lvl_mask_t clr_mask, set_mask;

  always_comb begin
    top_q    = first_set(isr_q);
    ceil_hit = top_q.hit;
    ceil_lvl = top_q.lvl;
    clr_mask = '0;
    set_mask = '0;
    if (clr_en && top_q.hit) clr_mask[top_q.lvl] = 1'b1;
    if (set_en)              set_mask[set_lvl]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~clr_mask) | set_mask;
  end

  p_set_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> isr_q[$past(set_lvl)]);

  p_reti_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && ceil_hit) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !set_en) |=> $stable(isr_q));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctl_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ*LVL_W-1:0] req_level,
  input  logic                     ceil_hit,
  input  level_t                   ceil_lvl,
  output logic                     grant_valid,
  output logic [IDX_W-1:0]         grant_idx,
  output level_t                   grant_level
);
  level_t             lvl_a [NUM_REQ];
  logic [NUM_REQ-1:0] elig;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    assign lvl_a[g] = req_level[g*LVL_W +: LVL_W];
    assign elig[g]  = req_valid[g] && (!ceil_hit || (lvl_a[g] < ceil_lvl));
  end

  always_comb begin
    grant_valid = 1'b0;
    grant_idx   = '0;
    grant_level = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (elig[i] && (!grant_valid || (lvl_a[i] < grant_level))) begin
        grant_valid = 1'b1;
        grant_idx   = IDX_W'(i);
        grant_level = lvl_a[i];
      end
    end
  end
endmodule

// File: rtl/irq_inservice_ctl.sv
module irq_inservice_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_REQ = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ*LVL_W-1:0] req_level,
  input  logic                     nmi_req,
  input  logic                     di_stb,
  input  logic                     ei_stb,
  input  logic                     reti_stb,
  input  logic                     reti_nmi,
  input  logic                     flag_wr_en,
  input  logic                     flag_wr_data,
  output logic                     ack_valid,
  output logic                     ack_nmi,
  output logic [IDX_W-1:0]         ack_index,
  output logic [LVL_W-1:0]         ack_level,
  output logic [NUM_LVL-1:0]       isr_bits,
  output logic                     int_disable
);
  logic             grant_valid, ceil_hit, m_take;
  logic [IDX_W-1:0] grant_idx;
  level_t           grant_level, ceil_lvl;

  irq_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pick (
    .req_valid  (req_valid),
    .req_level  (req_level),
    .ceil_hit   (ceil_hit),
    .ceil_lvl   (ceil_lvl),
    .grant_valid(grant_valid),
    .grant_idx  (grant_idx),
    .grant_level(grant_level)
  );

  // a non-maskable event pre-empts any maskable acknowledge in the same cycle
  assign m_take = grant_valid && !int_disable && !nmi_req;

  irq_isr_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (m_take),
    .set_lvl (grant_level),
    .clr_en  (reti_stb && !reti_nmi),
    .isr_q   (isr_bits),
    .ceil_hit(ceil_hit),
    .ceil_lvl(ceil_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid   <= 1'b0;
      ack_nmi     <= 1'b0;
      ack_index   <= '0;
      ack_level   <= '0;
      int_disable <= 1'b1;
    end else begin
      ack_valid <= m_take || nmi_req;
      ack_nmi   <= nmi_req;
      ack_index <= m_take ? grant_idx   : '0;
      ack_level <= m_take ? grant_level : '0;
      if (m_take)          int_disable <= 1'b1;
      else if (flag_wr_en) int_disable <= flag_wr_data;
      else if (di_stb)     int_disable <= 1'b1;
      else if (ei_stb)     int_disable <= 1'b0;
    end
  end

  p_mask_ack_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_nmi) |-> $past(!int_disable));

  p_ack_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_nmi) |-> int_disable);

  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_nmi) |=> !(ack_valid && !ack_nmi));

  p_grant_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_take |-> (!ceil_hit || (grant_level < ceil_lvl)));

  p_nmi_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !(reti_stb && !reti_nmi)) |=> ($stable(isr_bits) && ack_nmi && ack_valid));
endmodule

// File: tb/irq_inservice_ctl_test.sv
module irq_inservice_ctl_test;
  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NR-1:0] req_valid;
  logic [NR*3-1:0] req_level;
  logic nmi_req, di_stb, ei_stb, reti_stb, reti_nmi, flag_wr_en, flag_wr_data;
  logic       ack_valid, ack_nmi;
  logic [1:0] ack_index;
  logic [2:0] ack_level;
  logic [7:0] isr_bits;
  logic       int_disable;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_inservice_ctl #(.NUM_REQ(NR)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .nmi_req(nmi_req), .di_stb(di_stb), .ei_stb(ei_stb), .reti_stb(reti_stb),
    .reti_nmi(reti_nmi), .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .ack_valid(ack_valid), .ack_nmi(ack_nmi), .ack_index(ack_index),
    .ack_level(ack_level), .isr_bits(isr_bits), .int_disable(int_disable)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    req_valid = '0; req_level = '0; nmi_req = 0; di_stb = 0; ei_stb = 0;
    reti_stb = 0; reti_nmi = 0; flag_wr_en = 0; flag_wr_data = 0;
  endtask

  task automatic set_req(int i, int lvl);
    req_valid[i] = 1'b1;
    req_level[i*3 +: 3] = 3'(lvl);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  // take a single request at level lvl from a reset state (flag cleared by write)
  task automatic enter_level(int lvl);
    flag_wr_en = 1; flag_wr_data = 0; tick(); idle();
    set_req(0, lvl); tick(); idle();
  endtask

  task automatic t_reset();
    do_reset();
    tick();
    chk("R1 isr", isr_bits, 0);
    chk("R1 flag", int_disable, 1);
    chk("R1 ack", ack_valid, 0);
  endtask

  task automatic t_pending();
    do_reset();
    set_req(0, 5); tick();
    chk("R2 held while disabled", ack_valid, 0);
    ei_stb = 1; tick(); ei_stb = 0;
    chk("R2 no ack on enable edge", ack_valid, 0);
    chk("R8 ei clears", int_disable, 0);
    tick(); idle();
    chk("R2 ack after enable", ack_valid, 1);
    chk("R3 ack_nmi low", ack_nmi, 0);
    chk("R3 level", ack_level, 5);
    chk("R3 isr bit", isr_bits, 8'h20);
    chk("R3 flag set", int_disable, 1);
    tick();
    chk("R3 single pulse", ack_valid, 0);
  endtask

  task automatic t_arb();
    do_reset();
    flag_wr_en = 1; flag_wr_data = 0;
    set_req(0, 4); set_req(1, 2); set_req(2, 2); set_req(3, 6);
    tick(); flag_wr_en = 0;
    chk("R8 write loads", int_disable, 0);
    flag_wr_en = 1; flag_wr_data = 0;  // acknowledge must win over this write
    tick(); idle();
    chk("R4 winner index", ack_index, 1);
    chk("R4 winner level", ack_level, 2);
    chk("R3 isr", isr_bits, 8'h04);
    chk("R8 ack beats write", int_disable, 1);
  endtask

  task automatic t_nest();
    do_reset();
    enter_level(2);
    chk("R5 setup isr", isr_bits, 8'h04);
    ei_stb = 1; tick(); ei_stb = 0;
    set_req(3, 2); tick();
    chk("R5 equal level refused", ack_valid, 0);
    req_level[9 +: 3] = 3'd3; tick();
    chk("R5 lower priority refused", ack_valid, 0);
    req_level[9 +: 3] = 3'd1; tick(); idle();
    chk("R5 higher priority nests", ack_valid, 1);
    chk("R5 nested index", ack_index, 3);
    chk("R5 isr nested", isr_bits, 8'h06);
  endtask

  task automatic t_reti();
    do_reset();
    enter_level(5);
    ei_stb = 1; tick(); ei_stb = 0;
    set_req(1, 1); tick(); idle();
    chk("R6 setup", isr_bits, 8'h22);
    reti_stb = 1; reti_nmi = 1; tick(); idle();
    chk("R7 nmi return keeps isr", isr_bits, 8'h22);
    reti_stb = 1; tick(); idle();
    chk("R6 clears most urgent only", isr_bits, 8'h20);
    // level 3 must now be eligible (ceiling back to 5)
    ei_stb = 1; tick(); ei_stb = 0;
    set_req(2, 3); tick(); idle();
    chk("R6 ceiling lowered", ack_valid, 1);
    chk("R6 isr after", isr_bits, 8'h28);
    reti_stb = 1; tick(); tick(); tick(); idle();
    chk("R6 empty stays empty", isr_bits, 0);
  endtask

  task automatic t_flag();
    do_reset();
    ei_stb = 1; tick(); idle();
    chk("R8 ei", int_disable, 0);
    di_stb = 1; tick(); idle();
    chk("R8 di", int_disable, 1);
    ei_stb = 1; tick();
    di_stb = 1; tick(); idle();
    chk("R8 di beats ei", int_disable, 1);
    di_stb = 1; flag_wr_en = 1; flag_wr_data = 0; tick(); idle();
    chk("R8 write beats di", int_disable, 0);
    flag_wr_en = 1; flag_wr_data = 1; tick(); idle();
    chk("R8 write one", int_disable, 1);
  endtask

  task automatic t_nmi();
    do_reset();
    nmi_req = 1; tick(); idle();
    chk("R9 nmi while disabled", ack_valid, 1);
    chk("R9 ack_nmi", ack_nmi, 1);
    chk("R9 isr unchanged", isr_bits, 0);
    chk("R9 flag unchanged", int_disable, 1);
    ei_stb = 1; tick(); ei_stb = 0;
    set_req(2, 4); nmi_req = 1; tick(); nmi_req = 0;
    chk("R9 maskable held off", isr_bits, 0);
    chk("R9 flag still clear", int_disable, 0);
    tick(); idle();
    chk("R9 maskable after nmi", ack_nmi, 0);
    chk("R9 maskable isr", isr_bits, 8'h10);
  endtask

  initial begin
    idle();
    rst_n = 0;
    t_reset();
    t_pending();
    t_arb();
    t_nest();
    t_reti();
    t_flag();
    t_nmi();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule